// File: doc/BRIEF.md
# Wiper Tap Register with Power-Up Recall and Tap Decoder

This block is the digital control core of one digitally controlled potentiometer channel. It keeps a volatile tap register that names which switch of a series resistor array connects to the wiper node. Tap 0 is the switch at the low terminal of the array and tap `TAPS-1` is the switch at the high terminal. Every tap value is decoded into a one-hot enable vector with one bit per switch, so only one switch is ever closed.

After a power-up reset the register holds a fixed start tap. A small sequencer then requests the stored wiper setting from the nonvolatile register beside it and loads it. Once that load has happened, a recall-done flag rises and direct writes to the tap register are accepted. Incoming codes above `TAPS-1` are saturated, so the tap count does not have to be a power of two. The same RTL serves the 100-tap and the 256-tap arrays through the `TAPS` parameter.

Sequencer states: `ST_HOLD` is the reset state and lasts for the first edge after reset. `ST_FETCH` requests the recall. `ST_RUN` is normal operation. Transitions: T_START (`ST_HOLD`→`ST_FETCH`) happens unconditionally on the first clock edge after reset release. T_LOAD (`ST_FETCH`→`ST_RUN`) happens on the edge that samples `nv_valid` high. `ST_RUN` is left only by reset.

Top module: `wiper_ctrl`

## Requirements
- R1: While `rst_n` is low, `tap_code` equals `INIT_TAP`, `tap_sel` has only bit `INIT_TAP` set, and `recall_done` and `nv_req` are 0.
- R2: `nv_req` is 1 after the first rising clock edge that follows reset release. It stays 1 until a recall load takes place, and it is never 1 while `recall_done` is 1.
- R3: `tap_sel` always has exactly one bit set, at index `tap_code`. Bit 0 selects the low-terminal switch and bit `TAPS-1` selects the high-terminal switch.
- R4: A code above `TAPS-1` arriving from either `nv_data` or `wr_data` is stored as `TAPS-1`. `tap_code` never exceeds `TAPS-1`.
- R5: On the edge that samples `nv_valid` = 1 while `nv_req` = 1, `tap_code` takes the saturated `nv_data`. From that edge on, `recall_done` is 1 and `nv_req` is 0.
- R6: While `recall_done` is 0, `wr_en` has no effect on `tap_code` or `tap_sel`.
- R7: While `recall_done` is 1, an edge that samples `wr_en` = 1 loads the saturated `wr_data` into `tap_code`. `tap_code` and `tap_sel` show the new tap right after that edge.
- R8: While `recall_done` is 1, `nv_valid` and `nv_data` have no effect, and `recall_done` stays 1 until reset.
- R9: A reset applied during operation restores the R1 state, and the recall sequence runs again after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| nv_req | output | 1 | Request for the stored wiper setting |
| nv_valid | input | 1 | Stored setting present on `nv_data` |
| nv_data | input | CODE_W | Stored wiper setting |
| wr_en | input | 1 | Direct tap write strobe |
| wr_data | input | CODE_W | Direct tap write value |
| tap_code | output | CODE_W | Current tap register value |
| recall_done | output | 1 | Power-up recall has completed |
| tap_sel | output | TAPS | One-hot switch enables, bit 0 at the low terminal |

## Verification
The bench runs a 256-tap and a 100-tap instance side by side. It goes after codes just above and at the 100-tap limit (99, 100, 101, 127): a missing or off-by-one clamp would light no switch or the wrong one. It writes during the fetch window, where a design that opened writes too early would lose the recalled setting. It replays `nv_valid` after the recall, where a design with no guard would overwrite user writes. It also checks the extreme taps 0 and 255 and a reset issued mid-run, which must restart the recall.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RUN   = 2'd2
    } wiper_state_e;

    function automatic int code_width(input int taps);
        return (taps > 1) ? $clog2(taps) : 1;
    endfunction

endpackage

// File: rtl/wiper_clamp.sv
module wiper_clamp #(
    parameter int W     = 8,
    parameter int LIMIT = 255
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sat_o
);
    localparam logic [W-1:0] LIM = W'(LIMIT);
    localparam bit NEED_SAT = (LIMIT < (2 ** W) - 1);

    generate
        if (NEED_SAT) begin : g_sat
            assign sat_o = (raw_i > LIM) ? LIM : raw_i;
        end else begin : g_pass
            assign sat_o = raw_i;
        end
    endgenerate

endmodule

// File: rtl/wiper_decoder.sv
module wiper_decoder #(
    parameter int TAPS = 256,
    parameter int W    = 8
) (
    input  logic [W-1:0]    code_i,
    output logic [TAPS-1:0] onehot_o
);
    generate
        for (genvar i = 0; i < TAPS; i++) begin : g_tap
            assign onehot_o[i] = (code_i == W'(i));
        end
    endgenerate

endmodule

// File: rtl/wiper_seq.sv
module wiper_seq
    import wiper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nv_valid,
    input  logic wr_en,
    output logic nv_req,
    output logic recall_done,
    output logic load_nv,
    output logic load_wr
);
    wiper_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // next state: T_START, T_LOAD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_FETCH;
            ST_FETCH: if (nv_valid) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        nv_req      = 1'b0;
        recall_done = 1'b0;
        load_nv     = 1'b0;
        load_wr     = 1'b0;
        unique case (state_q)
            ST_HOLD:  ;
            ST_FETCH: begin
                nv_req  = 1'b1;
                load_nv = nv_valid;
            end
            ST_RUN: begin
                recall_done = 1'b1;
                load_wr     = wr_en;
            end
            default: ;
        endcase
    end

    p_req_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nv_req && recall_done));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recall_done |=> recall_done);

    p_load_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_nv && load_wr));

endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int TAPS     = 256,
    parameter int INIT_TAP = 0,
    parameter int CODE_W   = code_width(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              nv_req,
    input  logic              nv_valid,
    input  logic [CODE_W-1:0] nv_data,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] tap_code,
    output logic              recall_done,
    output logic [TAPS-1:0]   tap_sel
);
    localparam logic [CODE_W-1:0] LIM       = CODE_W'(TAPS - 1);
    localparam logic [CODE_W-1:0] INIT_CODE = CODE_W'(INIT_TAP);

    logic              load_nv, load_wr;
    logic [CODE_W-1:0] nv_sat, wr_sat, code_q;

    wiper_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .nv_valid    (nv_valid),
        .wr_en       (wr_en),
        .nv_req      (nv_req),
        .recall_done (recall_done),
        .load_nv     (load_nv),
        .load_wr     (load_wr)
    );

    wiper_clamp #(.W(CODE_W), .LIMIT(TAPS - 1)) u_clamp_nv (
        .raw_i (nv_data),
        .sat_o (nv_sat)
    );

    wiper_clamp #(.W(CODE_W), .LIMIT(TAPS - 1)) u_clamp_wr (
        .raw_i (wr_data),
        .sat_o (wr_sat)
    );

    // volatile tap register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= INIT_CODE;
        else if (load_nv) code_q <= nv_sat;
        else if (load_wr) code_q <= wr_sat;
    end

    assign tap_code = code_q;

    wiper_decoder #(.TAPS(TAPS), .W(CODE_W)) u_dec (
        .code_i   (code_q),
        .onehot_o (tap_sel)
    );

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1);

    p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tap_code <= LIM);

    p_recall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && nv_valid) |=> (recall_done && !nv_req &&
            tap_code == (($past(nv_data) > LIM) ? LIM : $past(nv_data))));

    p_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall_done && !nv_valid) |=> $stable(tap_code));

    p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_done && wr_en) |=>
            (tap_code == (($past(wr_data) > LIM) ? LIM : $past(wr_data))));

    p_nv_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_done && !wr_en) |=> $stable(tap_code));

endmodule

// File: tb/test_wiper_ctrl.sv
module test_wiper_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nv_valid = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] nv_b = '0, wr_b = '0;
    logic [6:0] nv_s = '0, wr_s = '0;

    logic         req_b, done_b, req_s, done_s;
    logic [7:0]   code_b;
    logic [6:0]   code_s;
    logic [255:0] sel_b;
    logic [99:0]  sel_s;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wiper_ctrl #(.TAPS(256), .INIT_TAP(0)) i_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .nv_req(req_b), .nv_valid(nv_valid),
        .nv_data(nv_b), .wr_en(wr_en), .wr_data(wr_b), .tap_code(code_b),
        .recall_done(done_b), .tap_sel(sel_b)
    );

    wiper_ctrl #(.TAPS(100), .INIT_TAP(0)) i_wiper_ctrl_small (
        .clk(clk), .rst_n(rst_n), .nv_req(req_s), .nv_valid(nv_valid),
        .nv_data(nv_s), .wr_en(wr_en), .wr_data(wr_s), .tap_code(code_s),
        .recall_done(done_s), .tap_sel(sel_s)
    );

    // {write value, expected 256-tap code, expected 100-tap code}
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {8'd0,   8'd0,   8'd0},
        {8'd1,   8'd1,   8'd1},
        {8'd37,  8'd37,  8'd37},
        {8'd98,  8'd98,  8'd98},
        {8'd99,  8'd99,  8'd99},
        {8'd100, 8'd100, 8'd99},
        {8'd101, 8'd101, 8'd99},
        {8'd126, 8'd126, 8'd99},
        {8'd127, 8'd127, 8'd99},
        {8'd64,  8'd64,  8'd64}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sel_idx_b();
        for (int i = 0; i < 256; i++) if (sel_b[i]) return i;
        return -1;
    endfunction

    function automatic int sel_idx_s();
        for (int i = 0; i < 100; i++) if (sel_s[i]) return i;
        return -1;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_taps(input string req, input int eb, input int es);
        chk(code_b == 8'(eb), req, "big code", int'(code_b), eb);
        chk($countones(sel_b) == 1 && sel_b[eb], req, "big sel", sel_idx_b(), eb);
        chk(code_s == 7'(es), req, "small code", int'(code_s), es);
        chk($countones(sel_s) == 1 && sel_s[es], req, "small sel", sel_idx_s(), es);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        chk_taps("R1", 0, 0);
        chk(!done_b && !done_s, "R1", "done", int'(done_b | done_s), 0);
        chk(!req_b && !req_s, "R1", "req", int'(req_b | req_s), 0);

        rst_n = 1'b1;
        step();
        // R2: request after first edge past release
        chk(req_b && req_s, "R2", "req", int'(req_b & req_s), 1);

        // R6: write before recall is dropped
        wr_en = 1'b1; wr_b = 8'd50; wr_s = 7'd50;
        step();
        wr_en = 1'b0;
        chk_taps("R6", 0, 0);
        chk(req_b && !done_b, "R2", "req held", int'(req_b), 1);

        // R5 + R4: recall with out-of-range small code
        nv_valid = 1'b1; nv_b = 8'd200; nv_s = 7'd120;
        step();
        nv_valid = 1'b0;
        chk_taps("R5", 200, 99);
        chk(done_b && done_s, "R5", "done", int'(done_b & done_s), 1);
        chk(!req_b && !req_s, "R5", "req drop", int'(req_b | req_s), 0);

        // R8: late recall data ignored
        nv_valid = 1'b1; nv_b = 8'd7; nv_s = 7'd7;
        step();
        step();
        nv_valid = 1'b0;
        chk_taps("R8", 200, 99);
        chk(done_b && done_s, "R8", "done sticky", int'(done_b & done_s), 1);

        // R7 / R3 / R4: vector table
        for (int k = 0; k < NV; k++) begin
            wr_en = 1'b1;
            wr_b  = VEC[k][23:16];
            wr_s  = VEC[k][22:16];
            step();
            wr_en = 1'b0;
            chk_taps("R7", int'(VEC[k][15:8]), int'(VEC[k][7:0]));
        end

        // R3: high terminal of large array, R4 saturation of max small code
        wr_en = 1'b1; wr_b = 8'd255; wr_s = 7'd127;
        step();
        wr_en = 1'b0;
        chk_taps("R3", 255, 99);
        step();
        chk_taps("R7", 255, 99);

        // R9: reset during operation
        rst_n = 1'b0;
        step();
        chk_taps("R9", 0, 0);
        chk(!done_b && !req_b && !done_s && !req_s, "R9", "flags", int'(done_b | req_b), 0);
        rst_n = 1'b1;
        step();
        chk(req_b && req_s, "R9", "req again", int'(req_b & req_s), 1);
        nv_valid = 1'b1; nv_b = 8'd5; nv_s = 7'd99;
        step();
        nv_valid = 1'b0;
        chk_taps("R9", 5, 99);
        chk(done_b && done_s, "R9", "done again", int'(done_b & done_s), 1);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule